// File: doc/BRIEF.md
# Low-Power Escape Transmitter for a Display Serial Lane

This block drives one display-serial data lane in low-power signalling mode. It is used to send short command and register writes to a panel. No high-speed clocking is involved. When it is idle it holds the two single-ended wires in the stop state (both high).

A start request makes the block run the escape-entry line sequence, then send an 8-bit escape command. For low-power data transmission that command is the byte 0x87, which appears on the wire as 11100001. After the command the block stays in escape mode. There it takes payload bytes one at a time over a valid/ready handshake, or takes an end request, which makes it send the exit mark and return to stop.

Each bit is sent with spaced-one-hot coding, least significant bit first. All timing is counted in unit intervals. One unit is a programmable number of system clocks, and a second setting stretches every entry and exit state. The block also gives a drive-enable for an external low-power output buffer, plus busy and done status.

Top module: `lpesc_tx`

## Requirements
- R1: After reset, and at all times while busy_o is low, the lane reads LP-11 (lp_p_o=1, lp_n_o=1), and lp_oe_o, ready_o and busy_o are 0. done_o is 0 except in the single cycle named in R6.
- R2: start_i high at a clock edge while idle starts a transfer. div_i is sampled as D and hold_i as H, and one unit is D+1 clocks. From the next cycle, busy_o and lp_oe_o are 1. The lane then shows LP-11, LP-10, LP-00, LP-01, LP-00 in that order, each for (H+1)*(D+1) clocks. The lane never steps straight from LP-11 to LP-00.
- R3: Right after entry, cmd_i (sampled with start_i) is sent least significant bit first. Every bit is a drive half followed by a space half (LP-00), each D+1 clocks long. The drive half is LP-10 (lp_p_o=1, lp_n_o=0) for a 1 and LP-01 for a 0.
- R4: After every byte the lane holds LP-00 with ready_o=1 until a byte or an end request is taken. A byte on data_i is taken at the clock edge where valid_i and ready_o are both 1. Its first drive half begins the next cycle, and escape entry is not repeated.
- R5: If valid_i and end_i are both high at an edge during the wait, the byte is taken and the end request is left pending.
- R6: end_i taken during the wait (with valid_i low) gives LP-10 then LP-11, each for (H+1)*(D+1) clocks. In the following cycle done_o is 1 for exactly one cycle, and busy_o and lp_oe_o return to 0.
- R7: start_i while busy has no effect. valid_i while ready_o is 0 is not taken, but a valid_i still held when the wait begins is taken at the first wait edge.
- R8: Changes to div_i or hold_i during a transfer do not change that transfer's timing.
- R9: An end request at the first wait gives a transfer that carries only the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a transfer (taken only while idle) |
| cmd_i | input | 8 | Escape command byte, sampled with start_i |
| div_i | input | DIV_W | Unit interval length minus one, in clocks |
| hold_i | input | HOLD_W | Units per entry/exit state, minus one |
| data_i | input | 8 | Payload byte |
| valid_i | input | 1 | Payload byte offered |
| end_i | input | 1 | Request the exit sequence |
| ready_o | output | 1 | Waiting between bytes, byte or end can be taken |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the exit stop state |
| lp_p_o | output | 1 | Low-power level for the positive wire |
| lp_n_o | output | 1 | Low-power level for the negative wire |
| lp_oe_o | output | 1 | Enable for the external low-power output buffer |

## Verification
The two functions that can meet in one cycle are taking a payload byte and taking an end request, since both are decided at the same wait edge. The bench raises valid_i and end_i together before a wait begins. It judges by the line state in the cycle after the edge: it must be the drive half of the byte's first bit (a 0 bit, so LP-01 and not the LP-10 exit mark). The exit must follow only after that byte. A start pulse in mid-transfer and mid-transfer changes of the timing inputs are judged by the same per-clock comparison against the bench's reference model. A decoder that rebuilds the bytes from the two wires is also compared against the bytes submitted.

// File: rtl/lpesc_pkg.sv
package lpesc_pkg;

    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned BIT_IDX_W    = $clog2(BYTE_W);
    localparam int unsigned ENTRY_STAGES = 5;
    localparam int unsigned STAGE_W      = $clog2(ENTRY_STAGES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_BIT_DRV,
        ST_BIT_SPC,
        ST_PAY_WAIT,
        ST_EXIT_MARK,
        ST_EXIT_STOP
    } seq_state_e;

    // Value is {p, n} as seen on the two wires.
    typedef enum logic [1:0] {
        LN_SPACE  = 2'b00,
        LN_MARK_N = 2'b01,
        LN_MARK_P = 2'b10,
        LN_STOP   = 2'b11
    } line_e;

    function automatic line_e entry_line(input logic [STAGE_W-1:0] stage);
        line_e l;
        case (stage)
            3'd0:    l = LN_STOP;
            3'd1:    l = LN_MARK_P;
            3'd2:    l = LN_SPACE;
            3'd3:    l = LN_MARK_N;
            default: l = LN_SPACE;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/lpesc_timer.sv
module lpesc_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i && (cnt_q != div_i)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && (cnt_q == div_i);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_i); // R2

    AST_TIMER_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/lpesc_seq.sv
module lpesc_seq
    import lpesc_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] cmd_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [HOLD_W-1:0] hold_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              valid_i,
    input  logic              end_i,
    input  logic              tick_i,
    output logic              run_o,
    output logic [DIV_W-1:0]  div_o,
    output line_e             line_d_o,
    output logic              drive_d_o,
    output logic              ready_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam logic [STAGE_W-1:0]   LAST_STAGE = STAGE_W'(ENTRY_STAGES - 1);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT   = BIT_IDX_W'(BYTE_W - 1);

    typedef struct packed {
        seq_state_e            st;
        logic [STAGE_W-1:0]    stage;
        logic [HOLD_W-1:0]     units;
        logic [DIV_W-1:0]      div;
        logic [HOLD_W-1:0]     hold;
        logic [BYTE_W-1:0]     sh;
        logic [BIT_IDX_W-1:0]  bitn;
        logic                  done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st    = ST_ENTRY;
                    seq_d.stage = '0;
                    seq_d.units = '0;
                    seq_d.div   = div_i;
                    seq_d.hold  = hold_i;
                    seq_d.sh    = cmd_i;
                    seq_d.bitn  = '0;
                end
            end
            ST_ENTRY: begin
                if (tick_i) begin
                    if (seq_q.units == seq_q.hold) begin
                        seq_d.units = '0;
                        if (seq_q.stage == LAST_STAGE) begin
                            seq_d.st = ST_BIT_DRV;
                        end else begin
                            seq_d.stage = seq_q.stage + 1'b1;
                        end
                    end else begin
                        seq_d.units = seq_q.units + 1'b1;
                    end
                end
            end
            ST_BIT_DRV: begin
                if (tick_i) begin
                    seq_d.st = ST_BIT_SPC;
                end
            end
            ST_BIT_SPC: begin
                if (tick_i) begin
                    if (seq_q.bitn == LAST_BIT) begin
                        seq_d.st = ST_PAY_WAIT;
                    end else begin
                        seq_d.st   = ST_BIT_DRV;
                        seq_d.sh   = {1'b0, seq_q.sh[BYTE_W-1:1]};
                        seq_d.bitn = seq_q.bitn + 1'b1;
                    end
                end
            end
            ST_PAY_WAIT: begin
                if (valid_i) begin
                    seq_d.st   = ST_BIT_DRV;
                    seq_d.sh   = data_i;
                    seq_d.bitn = '0;
                end else if (end_i) begin
                    seq_d.st    = ST_EXIT_MARK;
                    seq_d.units = '0;
                end
            end
            ST_EXIT_MARK: begin
                if (tick_i) begin
                    if (seq_q.units == seq_q.hold) begin
                        seq_d.st    = ST_EXIT_STOP;
                        seq_d.units = '0;
                    end else begin
                        seq_d.units = seq_q.units + 1'b1;
                    end
                end
            end
            ST_EXIT_STOP: begin
                if (tick_i) begin
                    if (seq_q.units == seq_q.hold) begin
                        seq_d.st    = ST_IDLE;
                        seq_d.units = '0;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.units = seq_q.units + 1'b1;
                    end
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, stage: '0, units: '0, div: '0,
                       hold: '0, sh: '0, bitn: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // Next line level, registered downstream together with the state.
    always_comb begin
        case (seq_d.st)
            ST_ENTRY:     line_d_o = entry_line(seq_d.stage);
            ST_BIT_DRV:   line_d_o = seq_d.sh[0] ? LN_MARK_P : LN_MARK_N;
            ST_BIT_SPC:   line_d_o = LN_SPACE;
            ST_PAY_WAIT:  line_d_o = LN_SPACE;
            ST_EXIT_MARK: line_d_o = LN_MARK_P;
            default:      line_d_o = LN_STOP;
        endcase
    end

    assign drive_d_o = (seq_d.st != ST_IDLE);
    assign run_o     = (seq_q.st != ST_IDLE) && (seq_q.st != ST_PAY_WAIT);
    assign div_o     = seq_q.div;
    assign ready_o   = (seq_q.st == ST_PAY_WAIT);
    assign busy_o    = (seq_q.st != ST_IDLE);
    assign done_o    = seq_q.done;

    AST_TIMING_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(seq_q.div) && $stable(seq_q.hold))); // R8

    AST_WAIT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !tick_i); // R4

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o); // R7

endmodule

// File: rtl/lpesc_line.sv
module lpesc_line
    import lpesc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_e code_d_i,
    input  logic  drive_d_i,
    output logic  lp_p_o,
    output logic  lp_n_o,
    output logic  lp_oe_o
);

    typedef struct packed {
        line_e code;
        logic  drive;
    } line_t;

    line_t ln_d, ln_q;

    always_comb begin
        ln_d       = ln_q;
        ln_d.code  = code_d_i;
        ln_d.drive = drive_d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '{code: LN_STOP, drive: 1'b0};
        end else begin
            ln_q <= ln_d;
        end
    end

    assign lp_p_o  = ln_q.code[1];
    assign lp_n_o  = ln_q.code[0];
    assign lp_oe_o = ln_q.drive;

    AST_UNDRIVEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !ln_q.drive |-> (ln_q.code == LN_STOP)); // R1

    AST_NO_STOP_TO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_q.code == LN_SPACE) |-> ($past(ln_q.code) != LN_STOP)); // R2

    AST_MARKS_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_q.code == LN_MARK_P) |-> ($past(ln_q.code) != LN_MARK_N)); // R3

endmodule

// File: rtl/lpesc_tx.sv
module lpesc_tx
    import lpesc_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        cmd_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [HOLD_W-1:0] hold_i,
    input  logic [7:0]        data_i,
    input  logic              valid_i,
    input  logic              end_i,
    output logic              ready_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              lp_p_o,
    output logic              lp_n_o,
    output logic              lp_oe_o
);

    logic             tick;
    logic             run;
    logic [DIV_W-1:0] div_cur;
    line_e            line_d;
    logic             drive_d;

    lpesc_timer #(.DIV_W(DIV_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_cur),
        .tick_o (tick)
    );

    lpesc_seq #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cmd_i     (cmd_i),
        .div_i     (div_i),
        .hold_i    (hold_i),
        .data_i    (data_i),
        .valid_i   (valid_i),
        .end_i     (end_i),
        .tick_i    (tick),
        .run_o     (run),
        .div_o     (div_cur),
        .line_d_o  (line_d),
        .drive_d_o (drive_d),
        .ready_o   (ready_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    lpesc_line line_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_d_i  (line_d),
        .drive_d_i (drive_d),
        .lp_p_o    (lp_p_o),
        .lp_n_o    (lp_n_o),
        .lp_oe_o   (lp_oe_o)
    );

    AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (lp_p_o && lp_n_o && !lp_oe_o && !ready_o)); // R1

    AST_WAIT_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!lp_p_o && !lp_n_o && lp_oe_o)); // R4

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(lp_p_o && lp_n_o && lp_oe_o)); // R6

endmodule

// File: tb/lpesc_tx_tb.sv
module lpesc_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] cmd_i = '0;
    logic [7:0] div_i = '0;
    logic [3:0] hold_i = '0;
    logic [7:0] data_i = '0;
    logic       valid_i = 1'b0;
    logic       end_i = 1'b0;
    logic       ready_o, busy_o, done_o, lp_p_o, lp_n_o, lp_oe_o;

    always #10 clk = ~clk;

    lpesc_tx dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .div_i(div_i), .hold_i(hold_i), .data_i(data_i), .valid_i(valid_i),
        .end_i(end_i), .ready_o(ready_o), .busy_o(busy_o), .done_o(done_o),
        .lp_p_o(lp_p_o), .lp_n_o(lp_n_o), .lp_oe_o(lp_oe_o)
    );

    int checks = 0;
    int failures = 0;
    string ovr = "";

    task automatic chk(input string tag, input bit ok, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    // expected {p, n, busy, ready, done}
    typedef logic [4:0] exp_t;
    exp_t  q[$];
    string tq[$];
    int    mode = 0;          // 0 idle, 1 sending, 2 waiting, 3 exiting
    int    m_div = 0, m_hold = 0;
    int    acc_cnt = 0;
    exp_t  cur = 5'b11000;
    string cur_tag = "R1";
    logic [7:0] sent[$];

    task automatic push_seg(input bit p, input bit n, input int clocks, input string t);
        for (int i = 0; i < clocks; i++) begin
            q.push_back({p, n, 1'b1, 1'b0, 1'b0});
            tq.push_back(t);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            push_seg(b[i], !b[i], m_div + 1, "R3");
            push_seg(1'b0, 1'b0, m_div + 1, "R3");
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 0;
            q.delete();
            tq.delete();
            cur = 5'b11000;
            cur_tag = "R1";
        end else begin
            int u;
            if (mode == 0 && start_i) begin
                m_div  = int'(div_i);
                m_hold = int'(hold_i);
                u = (m_hold + 1) * (m_div + 1);
                push_seg(1, 1, u, "R2");
                push_seg(1, 0, u, "R2");
                push_seg(0, 0, u, "R2");
                push_seg(0, 1, u, "R2");
                push_seg(0, 0, u, "R2");
                push_byte(cmd_i);
                sent.push_back(cmd_i);
                mode = 1;
            end else if (mode == 2 && valid_i) begin
                push_byte(data_i);
                sent.push_back(data_i);
                acc_cnt++;
                mode = 1;
            end else if (mode == 2 && end_i) begin
                u = (m_hold + 1) * (m_div + 1);
                push_seg(1, 0, u, "R6");
                push_seg(1, 1, u, "R6");
                mode = 3;
            end
            if (q.size() > 0) begin
                cur = q.pop_front();
                cur_tag = tq.pop_front();
            end else if (mode == 1 || mode == 2) begin
                mode = 2;
                cur = 5'b00110;
                cur_tag = "R4";
            end else if (mode == 3) begin
                mode = 0;
                cur = 5'b11001;
                cur_tag = "R6";
            end else begin
                cur = 5'b11000;
                cur_tag = "R1";
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [5:0] act, exp;
            act = {lp_p_o, lp_n_o, lp_oe_o, busy_o, ready_o, done_o};
            exp = {cur[4], cur[3], cur[2], cur[2], cur[1], cur[0]};
            chk((ovr.len() > 0) ? ovr : cur_tag, act == exp,
                "lane {p,n,oe,busy,ready,done}", int'(act), int'(exp));
        end
    end

    // ---------------- wire decoder ----------------
    logic [1:0] h0 = 2'b11, h1 = 2'b11, h2 = 2'b11, h3 = 2'b11;
    bit         in_esc = 0;
    logic [7:0] acc = '0;
    int         bitc = 0;
    logic [7:0] dec[$];
    int         last_dec_cnt = -1;

    always @(negedge clk) begin
        if (rst_n && ({lp_p_o, lp_n_o} != h0)) begin
            logic [1:0] s;
            s = {lp_p_o, lp_n_o};
            if (!in_esc) begin
                if (s == 2'b00 && h0 == 2'b01 && h1 == 2'b00 && h2 == 2'b10 && h3 == 2'b11) begin
                    in_esc = 1;
                    bitc = 0;
                    dec.delete();
                end
            end else if (s == 2'b00) begin
                acc[bitc] = (h0 == 2'b10);
                bitc++;
                if (bitc == 8) begin
                    dec.push_back(acc);
                    bitc = 0;
                end
            end else if (s == 2'b11) begin
                in_esc = 0;
                last_dec_cnt = dec.size();
                chk("R4", dec.size() == sent.size(), "decoded byte count",
                    dec.size(), sent.size());
                for (int i = 0; i < dec.size() && i < sent.size(); i++) begin
                    chk((i == 0) ? "R3" : "R4", dec[i] == sent[i], "decoded byte",
                        int'(dec[i]), int'(sent[i]));
                end
                sent.delete();
            end
            h3 = h2; h2 = h1; h1 = h0; h0 = s;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic begin_tx(input logic [7:0] c, input logic [7:0] d, input logic [3:0] h);
        while (mode != 0) @(negedge clk);
        cmd_i = c; div_i = d; hold_i = h; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        int k;
        k = acc_cnt;
        data_i = b; valid_i = 1'b1;
        do @(negedge clk); while (acc_cnt == k);
        valid_i = 1'b0;
    endtask

    task automatic finish_tx();
        end_i = 1'b1;
        do @(negedge clk); while (mode != 3);
        end_i = 1'b0;
        while (mode != 0) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {lp_p_o, lp_n_o, lp_oe_o, busy_o, ready_o, done_o} == 6'b110000,
            "reset state", int'({lp_p_o, lp_n_o, lp_oe_o, busy_o, ready_o, done_o}), 'h30);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // command plus three payload bytes, short units
        begin_tx(8'h87, 8'd1, 4'd0);
        send_byte(8'h29);
        send_byte(8'hFF);
        send_byte(8'h00);
        finish_tx();
        repeat (3) @(negedge clk);

        // R9: command only, stretched entry states, single-clock units
        begin_tx(8'h87, 8'd0, 4'd2);
        finish_tx();
        chk("R9", last_dec_cnt == 1, "bytes in command-only transfer", last_dec_cnt, 1);
        repeat (2) @(negedge clk);

        // R7 / R8 / R5 mixed
        begin_tx(8'h87, 8'd2, 4'd1);
        repeat (3) @(negedge clk);
        ovr = "R7";
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R7", busy_o == 1'b1, "busy after start while busy", busy_o, 1);
        @(negedge clk);
        ovr = "R8";
        div_i = 8'd5; hold_i = 4'd3;
        repeat (40) @(negedge clk);
        ovr = "R7";
        data_i = 8'h36; valid_i = 1'b1;   // offered before the wait
        chk("R7", ready_o == 1'b0, "ready while sending", ready_o, 0);
        begin
            int k;
            k = acc_cnt;
            do @(negedge clk); while (acc_cnt == k);
        end
        valid_i = 1'b0;
        ovr = "R5";
        data_i = 8'h02; valid_i = 1'b1; end_i = 1'b1;
        begin
            int k;
            k = acc_cnt;
            do @(negedge clk); while (acc_cnt == k && mode != 3);
            chk("R5", {lp_p_o, lp_n_o, ready_o} == 3'b010,
                "lane after byte and end together", int'({lp_p_o, lp_n_o, ready_o}), 'h2);
        end
        valid_i = 1'b0;
        ovr = "";
        do @(negedge clk); while (mode != 3);
        end_i = 1'b0;
        while (mode != 0) @(negedge clk);

        // back-to-back: start in the done cycle
        begin_tx(8'hA5, 8'd0, 4'd0);
        send_byte(8'h5A);
        finish_tx();
        begin_tx(8'h87, 8'd3, 4'd0);
        send_byte(8'h01);
        finish_tx();
        repeat (5) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule